// File: doc/BRIEF.md
# SD Data Path Transfer Controller

This block holds the control and counting part of the data path of an SD/SDIO host. Software loads a transfer length and then writes a control word. The control word holds an enable flag, a direction flag, a mode flag and a read-wait request. When that write carries the enable flag, the controller leaves its idle state. It enters a send-wait, receive-wait or read-wait state and copies the length into a remaining-byte counter. Byte-transfer strobes come from the serial engine, which lies outside this block. Each strobe lowers the counter by one. When the counter reaches zero, the controller returns to idle and raises a sticky data-end flag.

Control writes are throttled. Each accepted control write opens a hold window of card-clock plus bus-clock cycles, and further control writes inside that window are dropped. A transfer starts only on a fresh accepted control write. The enable flag merely staying at 1 does not start one. The remaining count can be read back at any time, zero-extended to the bus width.

Top module: `sd_dpath_ctrl`

## Requirements
- R1: After reset, state_o is 0 (idle), count_o is 0, data_end_o is 0 and ctrl_busy_o is 0.
- R2: An accepted control write (wr_sel_i=1) with bit 0 set in idle enters state 1 (send-wait) when bit 1 is 0, or state 2 (receive-wait) when bit 1 is 1, one cycle later, provided the length is nonzero and bit 3 is 0.
- R3: If bit 3 of that starting write is set, the state becomes 3 (read-wait). A later accepted control write with bit 3 clear moves read-wait to state 2.
- R4: On a start, count_o takes the length register value. The length register is written with wr_sel_i=0, and only the low 25 bits of wr_data_i are kept. count_o bits 31..25 always read 0.
- R5: In states 1 or 2, each byte_done_i pulse lowers count_o by one. The pulse that takes it to 0 returns the state to 0 and sets data_end_o on the same edge.
- R6: A start with a length of 0 leaves the state at 0 and sets data_end_o one cycle later, with no byte strobe.
- R7: data_end_o stays at 1 until a dend_clr_i pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R8: After a transfer ends, no new transfer starts while the stored enable stays 1. Only a new accepted control write with bit 0 set starts one.
- R9: An accepted control write holds ctrl_busy_o high for exactly 5 cycles (3 card plus 2 bus). Control writes made while it is high are ignored.
- R10: xfer_mode_o is 0 (block) when stored control bit 2 is 0. When bit 2 is 1, it is 1 (stream) with sdio_mode_i low and 2 (SDIO multibyte) with sdio_mode_i high.
- R11: A write with wr_sel_i=2 (count register) never changes count_o.
- R12: byte_done_i has no effect on count_o in state 0 or state 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select: 0 length, 1 control, 2 count |
| wr_data_i | input | 32 | Write data |
| sdio_mode_i | input | 1 | SDIO mode on |
| byte_done_i | input | 1 | One byte moved |
| dend_clr_i | input | 1 | Clear data-end flag |
| state_o | output | 2 | 0 idle, 1 send-wait, 2 receive-wait, 3 read-wait |
| count_o | output | 32 | Remaining bytes, zero-extended |
| data_end_o | output | 1 | Sticky transfer-finished flag |
| ctrl_busy_o | output | 1 | Control-write hold window active |
| xfer_mode_o | output | 2 | 0 block, 1 stream, 2 SDIO multibyte |

## Verification
The bench strobes a byte while the controller is idle and the counter is 0. A design that ignored the idle qualifier would wrap the count to all ones. A zero-length start checks that data-end is raised at once. A design that waited for a strobe would stick in a wait state. The bench also probes both edges of the hold window with a start attempt inside it. An off-by-one window would either let that start through or drop the first legal write. A separate sequence leaves read-wait and checks that strobes there are ignored, that the length's upper bits are masked, and that writes to the count register do nothing.

// File: rtl/sd_dpath_pkg.sv
package sd_dpath_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_RECV  = 2'd2,
    ST_RWAIT = 2'd3
  } dp_state_e;

  typedef enum logic [1:0] {
    XM_BLOCK  = 2'd0,
    XM_STREAM = 2'd1,
    XM_MULTI  = 2'd2
  } xfer_mode_e;

  localparam logic [1:0] SEL_LEN  = 2'd0;
  localparam logic [1:0] SEL_CTRL = 2'd1;
  localparam logic [1:0] SEL_CNT  = 2'd2;

  localparam int unsigned CB_EN   = 0;
  localparam int unsigned CB_DIR  = 1;
  localparam int unsigned CB_MODE = 2;
  localparam int unsigned CB_RWS  = 3;
endpackage

// File: rtl/sd_holdoff.sv
module sd_holdoff #(
  parameter int unsigned HOLD_CYC = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  output logic accept_o,
  output logic busy_o
);
  generate
    if (HOLD_CYC == 0) begin : g_nohold
      assign busy_o   = 1'b0;
      assign accept_o = wr_req_i;
    end else begin : g_hold
      localparam int unsigned HW = $clog2(HOLD_CYC + 1);
      logic [HW-1:0] hold_q;

      assign busy_o   = (hold_q != '0);
      assign accept_o = wr_req_i && !busy_o;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       hold_q <= '0;
        else if (accept_o) hold_q <= HW'(HOLD_CYC);
        else if (busy_o)   hold_q <= hold_q - 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/sd_xfer_cnt.sv
module sd_xfer_cnt #(
  parameter int unsigned CNT_W = 25
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - 1'b1;
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sd_dpath_fsm.sv
module sd_dpath_fsm
  import sd_dpath_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      rw_req_i,
  input  logic      dir_i,
  input  logic      rw_release_i,
  input  logic      byte_i,
  input  logic      len_zero_i,
  input  logic      last_i,
  output dp_state_e state_o,
  output logic      load_o,
  output logic      dec_o,
  output logic      done_o
);
  dp_state_e st_q, st_d;

  always_comb begin
    st_d   = st_q;
    load_o = 1'b0;
    dec_o  = 1'b0;
    done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o = 1'b1;
          if (len_zero_i)    done_o = 1'b1;
          else if (rw_req_i) st_d = ST_RWAIT;
          else               st_d = dir_i ? ST_RECV : ST_SEND;
        end
      end
      ST_RWAIT: begin
        if (rw_release_i) st_d = ST_RECV;
      end
      default: begin
        if (byte_i) begin
          dec_o = 1'b1;
          if (last_i) begin
            done_o = 1'b1;
            st_d   = ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/sd_dpath_ctrl.sv
module sd_dpath_ctrl
  import sd_dpath_pkg::*;
#(
  parameter int unsigned CNT_W     = 25,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned CARD_HOLD = 3,
  parameter int unsigned BUS_HOLD  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              sdio_mode_i,
  input  logic              byte_done_i,
  input  logic              dend_clr_i,
  output logic [1:0]        state_o,
  output logic [DATA_W-1:0] count_o,
  output logic              data_end_o,
  output logic              ctrl_busy_o,
  output logic [1:0]        xfer_mode_o
);
  localparam int unsigned HOLD_CYC = CARD_HOLD + BUS_HOLD;

  logic             ctrl_req, ctrl_acc, start, rw_release;
  logic             load, dec, done, last;
  logic             mode_q, dend_q;
  logic [CNT_W-1:0] len_q, cnt;
  dp_state_e        st;

  assign ctrl_req = wr_en_i && (wr_sel_i == SEL_CTRL);

  sd_holdoff #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (ctrl_req),
    .accept_o (ctrl_acc),
    .busy_o   (ctrl_busy_o)
  );

  // length register keeps only the counter width
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              len_q <= '0;
    else if (wr_en_i && wr_sel_i == SEL_LEN)  len_q <= wr_data_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       mode_q <= 1'b0;
    else if (ctrl_acc) mode_q <= wr_data_i[CB_MODE];
  end

  assign start      = ctrl_acc && wr_data_i[CB_EN];
  assign rw_release = ctrl_acc && !wr_data_i[CB_RWS];

  sd_dpath_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .rw_req_i     (wr_data_i[CB_RWS]),
    .dir_i        (wr_data_i[CB_DIR]),
    .rw_release_i (rw_release),
    .byte_i       (byte_done_i),
    .len_zero_i   (len_q == '0),
    .last_i       (last),
    .state_o      (st),
    .load_o       (load),
    .dec_o        (dec),
    .done_o       (done)
  );

  sd_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (len_q),
    .dec_i      (dec),
    .count_o    (cnt),
    .last_o     (last)
  );

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         dend_q <= 1'b0;
    else if (done)       dend_q <= 1'b1;
    else if (dend_clr_i) dend_q <= 1'b0;
  end

  always_comb begin
    if (!mode_q)          xfer_mode_o = XM_BLOCK;
    else if (sdio_mode_i) xfer_mode_o = XM_MULTI;
    else                  xfer_mode_o = XM_STREAM;
  end

  assign state_o    = st;
  assign count_o    = DATA_W'(cnt);
  assign data_end_o = dend_q;
endmodule

// File: rtl/sd_dpath_ctrl_chk.sv
module sd_dpath_ctrl_chk #(
  parameter int unsigned CNT_W  = 25,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [1:0]        wr_sel_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              byte_done_i,
  input logic              dend_clr_i,
  input logic [1:0]        state_o,
  input logic [DATA_W-1:0] count_o,
  input logic              data_end_o,
  input logic              ctrl_busy_o,
  input logic [CNT_W-1:0]  len_q
);
  logic ctrl_wr, acc_start;
  assign ctrl_wr   = wr_en_i && wr_sel_i == 2'd1;
  assign acc_start = ctrl_wr && !ctrl_busy_o && wr_data_i[0];

  p_start_send_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 && acc_start && !wr_data_i[1] && !wr_data_i[3] && len_q != '0
    |=> state_o == 2'd1 && count_o == DATA_W'($past(len_q)));

  p_rwait_exit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd3 && ctrl_wr && !ctrl_busy_o && !wr_data_i[3] |=> state_o == 2'd2);

  p_dec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 || state_o == 2'd2) && byte_done_i && count_o > 1
    |=> count_o == $past(count_o) - 1);

  p_finish_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd1 || state_o == 2'd2) && byte_done_i && count_o == 1
    |=> state_o == 2'd0 && data_end_o);

  p_dend_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_end_o && !dend_clr_i |=> data_end_o);

  p_busy_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 2'd0 && ctrl_wr && ctrl_busy_o |=> state_o == 2'd0);

  p_cnt_wr_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_sel_i == 2'd2 && !byte_done_i |=> $stable(count_o));

  p_idle_byte_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 2'd0 || state_o == 2'd3) && !acc_start && byte_done_i |=> $stable(count_o));

  p_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dend_clr_i && state_o == 2'd0 && !acc_start |=> !data_end_o);
endmodule

bind sd_dpath_ctrl sd_dpath_ctrl_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .wr_data_i   (wr_data_i),
  .byte_done_i (byte_done_i),
  .dend_clr_i  (dend_clr_i),
  .state_o     (state_o),
  .count_o     (count_o),
  .data_end_o  (data_end_o),
  .ctrl_busy_o (ctrl_busy_o),
  .len_q       (len_q)
);

// File: tb/sd_dpath_ctrl_test.sv
`timescale 1ns/1ps
module sd_dpath_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        sdio = 1'b0, byte_done = 1'b0, dend_clr = 1'b0;
  logic [1:0]  state, xmode;
  logic [31:0] count;
  logic        dend, busy;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sd_dpath_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .sdio_mode_i(sdio), .byte_done_i(byte_done),
    .dend_clr_i(dend_clr), .state_o(state), .count_o(count),
    .data_end_o(dend), .ctrl_busy_o(busy), .xfer_mode_o(xmode)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  int          m_state, m_busy;
  logic [24:0] m_cnt, m_len;
  bit          m_mode, m_dend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_busy = 0; m_cnt = '0; m_len = '0; m_mode = 0; m_dend = 0;
    end else begin
      bit acc, set_end;
      int ns, nb;
      logic [24:0] nc, nl;
      bit nm, nd;
      acc = wr_en && wr_sel == 2'd1 && m_busy == 0;
      ns = m_state; nb = m_busy; nc = m_cnt; nl = m_len; nm = m_mode; nd = m_dend;
      set_end = 0;
      if (wr_en && wr_sel == 2'd0) nl = wr_data[24:0];
      if (acc) begin nm = wr_data[2]; nb = 5; end
      else if (m_busy > 0) nb = m_busy - 1;
      case (m_state)
        0: if (acc && wr_data[0]) begin
             nc = m_len;
             if (m_len == 0) set_end = 1;
             else if (wr_data[3]) ns = 3;
             else ns = wr_data[1] ? 2 : 1;
           end
        3: if (acc && !wr_data[3]) ns = 2;
        default: if (byte_done) begin
             nc = m_cnt - 1;
             if (nc == 0) begin ns = 0; set_end = 1; end
           end
      endcase
      if (set_end) nd = 1;
      else if (dend_clr) nd = 0;
      m_state = ns; m_busy = nb; m_cnt = nc; m_len = nl; m_mode = nm; m_dend = nd;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_n) begin
      check("R2 model state", 32'(state), 32'(m_state));
      check("R5 model count", count, 32'(m_cnt));
      check("R7 model data_end", 32'(dend), 32'(m_dend));
      check("R9 model busy", 32'(busy), 32'(m_busy != 0));
      check("R10 model mode", 32'(xmode), !m_mode ? 32'd0 : (sdio ? 32'd2 : 32'd1));
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_sel = 2'd0;
  endtask

  task automatic strobe();
    byte_done = 1'b1;
    @(negedge clk);
    byte_done = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    check("R1 state", 32'(state), 0);
    check("R1 count", count, 0);
    check("R1 data_end", 32'(dend), 0);
    check("R1 busy", 32'(busy), 0);

    // send transfer of 3
    wr(2'd0, 32'd3);
    wr(2'd1, 32'h1);
    check("R2 send state", 32'(state), 1);
    check("R4 load", count, 3);
    idle(5);
    strobe(); idle(1); strobe();
    check("R5 decrement", count, 1);
    strobe();
    check("R5 end state", 32'(state), 0);
    check("R5 data_end", 32'(dend), 1);
    idle(3);
    check("R7 sticky", 32'(dend), 1);
    dend_clr = 1'b1; @(negedge clk); dend_clr = 1'b0;
    check("R7 cleared", 32'(dend), 0);

    // enable still stored: no restart
    wr(2'd0, 32'd7);
    idle(3);
    check("R8 no restart", 32'(state), 0);
    strobe();
    check("R12 idle strobe", count, 0);

    // zero-length start
    wr(2'd0, 32'd0);
    wr(2'd1, 32'h1);
    check("R6 stays idle", 32'(state), 0);
    check("R6 data_end", 32'(dend), 1);
    dend_clr = 1'b1; @(negedge clk); dend_clr = 1'b0;

    // holdoff window
    wr(2'd0, 32'd4);
    idle(5);
    wr(2'd1, 32'h0);
    wr(2'd1, 32'h3);
    check("R9 blocked start", 32'(state), 0);
    idle(3);
    check("R9 still busy", 32'(busy), 1);
    idle(1);
    check("R9 window over", 32'(busy), 0);
    wr(2'd1, 32'h3);
    check("R2 recv state", 32'(state), 2);
    wr(2'd2, 32'h55);
    check("R11 count write ignored", count, 4);
    repeat (4) strobe();
    check("R5 recv done", 32'(state), 0);
    dend_clr = 1'b1; @(negedge clk); dend_clr = 1'b0;

    // read-wait path
    idle(5);
    wr(2'd0, 32'd2);
    wr(2'd1, 32'h9);
    check("R3 read-wait", 32'(state), 3);
    strobe();
    check("R12 read-wait strobe", count, 2);
    idle(5);
    wr(2'd1, 32'h1);
    check("R3 release", 32'(state), 2);
    strobe(); strobe();
    check("R5 rw done", 32'(state), 0);

    // set beats clear
    idle(5);
    wr(2'd0, 32'd1);
    wr(2'd1, 32'h1);
    idle(5);
    byte_done = 1'b1; dend_clr = 1'b1;
    @(negedge clk);
    byte_done = 1'b0; dend_clr = 1'b0;
    check("R7 set wins", 32'(dend), 1);

    // mode decode
    wr(2'd1, 32'h4);
    sdio = 1'b0; @(negedge clk);
    check("R10 stream", 32'(xmode), 1);
    sdio = 1'b1; @(negedge clk);
    check("R10 multibyte", 32'(xmode), 2);
    idle(5);
    wr(2'd1, 32'h0);
    check("R10 block", 32'(xmode), 0);

    // length masking and upper bits
    idle(5);
    wr(2'd0, 32'hFFFF_FFFF);
    wr(2'd1, 32'h1);
    check("R4 masked load", count, 32'h01FF_FFFF);
    strobe();
    check("R4 upper zero", count & 32'hFE00_0000, 0);
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule